// File: doc/BRIEF.md
# Five-Level Converter Leg Switch Sequencer

This block drives the four series gate signals of one asymmetric neutral-point-clamped converter leg that feeds a single motor phase winding. A controller asks for one of three settled output levels (positive rail, zero, negative rail). The block walks the leg to that level one switch at a time. Each step passes through a half-voltage state that is held for a fixed number of clock cycles, and the block picks among the redundant switch patterns so that the two split capacitors stay balanced.

The choice between the two redundant sides is made only when the leg leaves a full-rail level. Without a bias request, successive departures alternate between the sides. A bias request picks the side that pulls charge off the over-charged capacitor. A departure from zero keeps the side of the zero pattern the leg is already in. While the leg is moving, a busy flag is high and new requests are dropped.

Top module: `npc_leg_sequencer`

## Requirements
- R1: During and after a synchronous reset, all four gates are off (`gate_o` = 0000) and `busy_o` is low.
- R2: `gate_o[3]` is the outer upper switch, `[2]` the inner upper, `[1]` the inner lower, `[0]` the outer lower. The request code is 00 for the negative rail, 01 for zero, 10 for the positive rail, and 11 is illegal. A settled positive rail is 1111 and a settled negative rail is 0000.
- R3: Side A uses half-up 1110, zero 1100 and half-down 0100. Side B uses half-up 0111, zero 0011 and half-down 0010.
- R4: Between two consecutive cycles at most one gate changes. An outer switch turns on only after its inner neighbour is on, and it turns off while its inner neighbour stays on.
- R5: Every half-voltage state lasts exactly DWELL_CYC cycles. A zero state that is only passed through lasts one cycle.
- R6: A move follows the ladder negative rail, half-down, zero, half-up, positive rail, in either direction, one rung per step. The first step appears on the clock edge that accepts the request.
- R7: After reset the first unbiased departure from a full rail uses side A. Each later unbiased departure uses the side opposite the previous unbiased one.
- R8: When `bias_valid` is high at acceptance of a departure from a full rail, the side is chosen by the bias. From the positive rail, side A is used if `bias_upper` is 1 and side B if it is 0. From the negative rail, side B is used if `bias_upper` is 1 and side A if it is 0. A biased departure does not advance the alternation.
- R9: `busy_o` is high from the accepting edge until the target level is settled. Requests made while busy are ignored.
- R10: An illegal code, or a request for the level already settled, leaves the gates unchanged and `busy_o` low.
- R11: A departure from zero keeps the side of the present zero pattern, whatever the bias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Level request strobe |
| req_lvl | input | 2 | Requested level: 00 negative, 01 zero, 10 positive |
| bias_valid | input | 1 | Capacitor balance correction requested |
| bias_upper | input | 1 | 1 when the upper capacitor holds excess charge |
| gate_o | output | 4 | Gates {outer upper, inner upper, inner lower, outer lower} |
| busy_o | output | 1 | Leg is moving between levels |

## Verification
Two things can happen in the same cycle: a new request, and the dwell timer expiring while the leg is still moving. The bench provokes this by raising a conflicting request during the first half-voltage dwell. It then checks that the path, the dwell length and the final level are exactly those of the original request. The second overlap is a bias request arriving at the same moment as an alternation decision. A sweep over every target and bias setting, starting from every settled level, checks that the bias wins only on departures from a full rail and leaves the alternation sequence unchanged.

// File: rtl/npcseq_pkg.sv
package npcseq_pkg;

  // Gate vector {outer upper, inner upper, inner lower, outer lower}
  typedef enum logic [3:0] {
    P_ALL_OFF   = 4'b0000,
    P_HDN_A     = 4'b0100,
    P_HDN_B     = 4'b0010,
    P_ZERO_A    = 4'b1100,
    P_ZERO_MID  = 4'b0110,
    P_ZERO_B    = 4'b0011,
    P_HUP_A     = 4'b1110,
    P_HUP_B     = 4'b0111,
    P_FULL_ON   = 4'b1111
  } leg_pat_t;

  typedef enum logic [1:0] {
    LV_NEG  = 2'b00,
    LV_ZERO = 2'b01,
    LV_POS  = 2'b10,
    LV_BAD  = 2'b11
  } lvl_t;

  function automatic logic is_half(input leg_pat_t p);
    return (p == P_HDN_A) || (p == P_HDN_B) || (p == P_HUP_A) || (p == P_HUP_B);
  endfunction

  // Settled level of a pattern; transitional patterns map to LV_BAD
  function automatic lvl_t lvl_of(input leg_pat_t p);
    lvl_t l;
    case (p)
      P_ALL_OFF:                       l = LV_NEG;
      P_FULL_ON:                       l = LV_POS;
      P_ZERO_A, P_ZERO_MID, P_ZERO_B:  l = LV_ZERO;
      default:                         l = LV_BAD;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/npcseq_dwell_timer.sv
module npcseq_dwell_timer #(
  parameter int DWELL_CYC = 250,
  localparam int CNT_W = $clog2(DWELL_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic done
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(DWELL_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  assert_no_overrun_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/npcseq_side_picker.sv
module npcseq_side_picker (
  input  logic clk,
  input  logic rst,
  input  logic pick,        // departure from a full rail accepted this cycle
  input  logic from_top,    // 1: leaving the positive rail
  input  logic bias_valid,
  input  logic bias_upper,
  output logic side_o       // 0: side A, 1: side B
);
  logic alt_q;

  always_comb begin
    if (bias_valid) side_o = from_top ? ~bias_upper : bias_upper;
    else            side_o = alt_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                     alt_q <= 1'b0;
    else if (pick && !bias_valid) alt_q <= ~alt_q;
  end

  assert_bias_holds_alt_R8: assert property (@(posedge clk) disable iff (rst)
    (pick && bias_valid) |=> (alt_q == $past(alt_q)));
  assert_alt_flips_R7: assert property (@(posedge clk) disable iff (rst)
    (pick && !bias_valid) |=> (alt_q != $past(alt_q)));
endmodule

// File: rtl/npcseq_step_table.sv
module npcseq_step_table
  import npcseq_pkg::*;
(
  input  leg_pat_t cur,
  input  lvl_t     tgt,
  input  logic     side,
  output leg_pat_t nxt
);
  always_comb begin
    nxt = cur;
    case (cur)
      P_ALL_OFF:  if (tgt == LV_ZERO || tgt == LV_POS) nxt = side ? P_HDN_B : P_HDN_A;
      P_HDN_A:    nxt = (tgt == LV_NEG) ? P_ALL_OFF : P_ZERO_A;
      P_HDN_B:    nxt = (tgt == LV_NEG) ? P_ALL_OFF : P_ZERO_B;
      P_ZERO_A: begin
        if (tgt == LV_POS)      nxt = P_HUP_A;
        else if (tgt == LV_NEG) nxt = P_HDN_A;
      end
      P_ZERO_B: begin
        if (tgt == LV_POS)      nxt = P_HUP_B;
        else if (tgt == LV_NEG) nxt = P_HDN_B;
      end
      P_ZERO_MID: begin
        if (tgt == LV_POS)      nxt = P_HUP_A;
        else if (tgt == LV_NEG) nxt = P_HDN_A;
      end
      P_HUP_A:    nxt = (tgt == LV_POS) ? P_FULL_ON : P_ZERO_A;
      P_HUP_B:    nxt = (tgt == LV_POS) ? P_FULL_ON : P_ZERO_B;
      P_FULL_ON:  if (tgt == LV_ZERO || tgt == LV_NEG) nxt = side ? P_HUP_B : P_HUP_A;
      default:    nxt = P_ALL_OFF;
    endcase
  end
endmodule

// File: rtl/npc_leg_sequencer.sv
module npc_leg_sequencer
  import npcseq_pkg::*;
#(
  parameter int DWELL_CYC = 250,
  localparam int CNT_W = $clog2(DWELL_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_lvl,
  input  logic       bias_valid,
  input  logic       bias_upper,
  output logic [3:0] gate_o,
  output logic       busy_o
);
  leg_pat_t pat_q, step_nxt;
  lvl_t     tgt_q, req_l, step_tgt, cur_lvl;
  logic     busy, accept, advance, side, tmr_done, leaving_full;

  assign req_l   = lvl_t'(req_lvl);
  assign cur_lvl = lvl_of(pat_q);
  assign busy    = (cur_lvl != tgt_q);
  assign accept  = req_valid && !busy && (req_l != LV_BAD) && (req_l != cur_lvl);
  assign leaving_full = accept && (pat_q == P_FULL_ON || pat_q == P_ALL_OFF);
  assign advance = accept || (busy && (!is_half(pat_q) || tmr_done));
  assign step_tgt = accept ? req_l : tgt_q;

  npcseq_side_picker u_side (
    .clk        (clk),
    .rst        (rst),
    .pick       (leaving_full),
    .from_top   (pat_q == P_FULL_ON),
    .bias_valid (bias_valid),
    .bias_upper (bias_upper),
    .side_o     (side)
  );

  npcseq_step_table u_step (
    .cur  (pat_q),
    .tgt  (step_tgt),
    .side (side),
    .nxt  (step_nxt)
  );

  npcseq_dwell_timer #(.DWELL_CYC(DWELL_CYC)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .load (advance && is_half(step_nxt)),
    .done (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q <= P_ALL_OFF;
      tgt_q <= LV_NEG;
    end else begin
      if (accept)  tgt_q <= req_l;
      if (advance) pat_q <= step_nxt;
    end
  end

  assign gate_o = pat_q;
  assign busy_o = busy;

  // Run length of the present half-voltage pattern
  leg_pat_t         prev_q;
  logic [CNT_W:0]   hrun_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= P_ALL_OFF;
      hrun_q <= '0;
    end else begin
      prev_q <= pat_q;
      if (!is_half(pat_q))     hrun_q <= '0;
      else if (pat_q != prev_q) hrun_q <= 1;
      else if (hrun_q != '1)   hrun_q <= hrun_q + 1'b1;
    end
  end

  assert_reset_off_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (gate_o == 4'b0000 && !busy_o));
  assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(gate_o ^ $past(gate_o)) <= 1);
  assert_top_on_last_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_o[3]) |-> $past(gate_o[2]));
  assert_top_off_first_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_o[3]) |-> gate_o[2]);
  assert_bot_on_last_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_o[0]) |-> $past(gate_o[1]));
  assert_bot_off_first_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_o[0]) |-> gate_o[1]);
  assert_dwell_bound_R5: assert property (@(posedge clk) disable iff (rst)
    hrun_q <= (CNT_W+1)'(DWELL_CYC));
  assert_half_busy_R9: assert property (@(posedge clk) disable iff (rst)
    is_half(pat_q) |-> busy_o);
  assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (tgt_q == $past(tgt_q)));
endmodule

// File: tb/sim_npc_leg_sequencer.sv
`timescale 1ns/1ps
module sim_npc_leg_sequencer;
  localparam int DW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_lvl = 2'b00;
  logic bias_valid = 1'b0;
  logic bias_upper = 1'b0;
  logic [3:0] gate_o;
  logic busy_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  int cur_pos = 0;   // 0 neg, 2 zero, 4 pos
  bit alt = 0;
  bit zside = 0;

  always #2 clk = ~clk;

  npc_leg_sequencer #(.DWELL_CYC(DW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_lvl(req_lvl),
    .bias_valid(bias_valid), .bias_upper(bias_upper),
    .gate_o(gate_o), .busy_o(busy_o)
  );

  function automatic logic [3:0] pat_at(int p, bit s);
    case (p)
      0: return 4'b0000;
      1: return s ? 4'b0010 : 4'b0100;
      2: return s ? 4'b0011 : 4'b1100;
      3: return s ? 4'b0111 : 4'b1110;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic check(string tag, logic [3:0] eg, logic eb);
    n_run++;
    if (gate_o !== eg || busy_o !== eb) begin
      n_fail++;
      $display("FAIL %s: gate=%b busy=%b expected gate=%b busy=%b", tag, gate_o, busy_o, eg, eb);
    end
  endtask

  // lvl code: 0 neg, 1 zero, 2 pos, 3 illegal
  task automatic run_req(int code, bit bv, bit bu, bit inj, string tag);
    int tpos;
    bit s;
    int dir;
    int p;
    tpos = code * 2;
    @(negedge clk);
    req_valid = 1'b1; req_lvl = 2'(code); bias_valid = bv; bias_upper = bu;
    if (code == 3 || tpos == cur_pos) begin
      @(negedge clk);
      req_valid = 1'b0; bias_valid = 1'b0;
      for (int k = 0; k < 3; k++) begin
        check({tag, " R10 ignored request"}, pat_at(cur_pos, zside), 1'b0);
        @(negedge clk);
      end
      return;
    end
    if (cur_pos == 2) s = zside;                   // R11
    else if (bv) s = (cur_pos == 4) ? ~bu : bu;    // R8
    else begin s = alt; alt = ~alt; end            // R7
    dir = (tpos > cur_pos) ? 1 : -1;
    @(negedge clk);
    req_valid = 1'b0; bias_valid = 1'b0;
    p = cur_pos + dir;
    while (p != tpos) begin
      int dur;
      dur = (p % 2 == 1) ? DW : 1;
      for (int k = 0; k < dur; k++) begin
        if (inj && p == cur_pos + dir && k == 0) begin
          req_valid = 1'b1; req_lvl = 2'(cur_pos / 2);
          bias_valid = 1'b1; bias_upper = ~s;
        end
        check({tag, " R6 R5 R3 path"}, pat_at(p, s), 1'b1);
        @(negedge clk);
        req_valid = 1'b0; bias_valid = 1'b0;
      end
      p = p + dir;
    end
    check({tag, " R2 R9 settled"}, pat_at(tpos, s), 1'b0);
    if (tpos == 2) zside = s;
    cur_pos = tpos;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 4'b0000, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", 4'b0000, 1'b0);
    run_req(2, 0, 0, 0, "R7 first up side A");
    run_req(1, 0, 0, 0, "R7 chop down side B");
    run_req(2, 1, 1, 0, "R11 zero keeps side");
    run_req(1, 0, 0, 0, "R7 next unbiased A");
    run_req(2, 0, 0, 0, "R6 up");
    run_req(1, 1, 1, 0, "R8 top upper->A");
    run_req(2, 0, 0, 0, "R6 up");
    run_req(1, 1, 0, 0, "R8 top lower->B");
    run_req(0, 0, 0, 0, "R6 zero to neg");
    run_req(2, 1, 1, 0, "R8 bottom upper->B");
    run_req(0, 0, 0, 1, "R9 busy ignore");
    run_req(1, 1, 0, 0, "R8 bottom lower->A");
    run_req(3, 0, 0, 0, "R10 illegal");
    run_req(1, 0, 0, 0, "R10 same level");
    for (int rep = 0; rep < 4; rep++)
      for (int t = 0; t < 4; t++)
        for (int b = 0; b < 3; b++)
          run_req(t, b != 0, b == 2, rep == 1, "R4 sweep");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule